// File: doc/BRIEF.md
# Nonvolatile Program Sequencer with Write Protection

This block sits behind the serial command decoder of a small EEPROM and decides whether an erase or program operation may touch the storage array. It holds an erase/write enable latch, gates every program request with the program-enable input and the power-good signal, and then runs the self-timed cycle. The cycle drives a simple write port on the array and holds a busy flag for a programmable number of system clocks.

Commands arrive as one beat on a valid/ready stream that carries an opcode, an address and a data word. The block never applies back-pressure, so `cmd_ready` is always high. A beat is taken on every clock in which `cmd_valid` is high. Any beat that cannot act is consumed and dropped: the block is busy, power is bad, the enable latch is clear, the program-enable input is low, or the opcode is unknown. A single-word write erases the word to all ones before it programs the new value. A full-array write first erases every location and then programs every location.

The cycle-time parameters must satisfy T_WORD_CYC >= 2 and T_ERAL_CYC >= DEPTH. T_WRAL_CYC must be at least 2*DEPTH, so that the array sweep ends inside the timed window.

Top module: `wp_prog_sequencer`

## Requirements
- R1: After reset, `busy` and `arr_we` are low, `cmd_ready` is high, and the enable latch is clear, so a program request with no prior enable is dropped.
- R2: Opcode encoding on `cmd_op`: 1 enables programming, 2 disables it, 3 erases one word, 4 writes one word, 5 erases the whole array, 6 writes the whole array. A program request (3 to 6) is dropped while the latch is clear.
- R3: While `prog_en` is low, every program request is dropped, with no array write and no busy.
- R4: A word erase writes all ones to `cmd_addr` exactly once and holds `busy` for T_WORD_CYC cycles.
- R5: A word write issues two array writes to `cmd_addr`, first all ones and then `cmd_data`, and holds `busy` for T_WORD_CYC cycles.
- R6: A full erase writes all ones to every location (DEPTH writes) and holds `busy` for T_ERAL_CYC cycles.
- R7: A full write first erases every location and only then writes `cmd_data` to every location (2*DEPTH writes in total), holding `busy` for T_WRAL_CYC cycles.
- R8: Any beat accepted while `busy` is high is dropped. This includes a disable, so the latch keeps its state.
- R9: While `power_good` is low, any running cycle is aborted on the next clock (`busy` and `arr_we` go low), the latch is cleared, and every beat is dropped, an enable included.
- R10: The latch stays set after a completed program cycle, so a following program request is accepted without a new enable.
- R11: Opcodes 0 and 7 have no effect: no array write, no busy, and no change to the latch.
- R12: `cmd_ready` is high in every cycle, while busy included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| power_good | input | 1 | Supply above its detect threshold |
| prog_en | input | 1 | Program-enable; low protects the whole array |
| cmd_valid | input | 1 | Command beat valid |
| cmd_ready | output | 1 | Always high; the block never stalls a beat |
| cmd_op | input | 3 | Command opcode (see R2) |
| cmd_addr | input | AW | Word address |
| cmd_data | input | DW | Data word for writes |
| busy | output | 1 | Program cycle in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | AW | Array write address |
| arr_wdata | output | DW | Array write data |

## Verification
The bench sweeps a word write over every address and compares a model of the whole array after each one. A design that wrote the wrong location, or that skipped the pre-erase, would show a mismatch or a wrong write count. It checks that data writes never appear before the last erase write of a full write; a design with the sweep phases swapped or interleaved would fail that check. It fires a disable and a write while busy, then confirms that the latch survived by starting a new write. It drops power in the middle of a sweep and confirms that an enable given during low power does not stick.

// File: rtl/wp_seq_pkg.sv
package wp_seq_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_EWEN  = 3'd1,
    OP_EWDS  = 3'd2,
    OP_ERASE = 3'd3,
    OP_WRITE = 3'd4,
    OP_ERAL  = 3'd5,
    OP_WRAL  = 3'd6
  } wp_op_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CLR  = 2'd1,
    PH_PROG = 2'd2
  } wp_phase_e;
endpackage

// File: rtl/wp_enable_latch.sv
module wp_enable_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic power_good,
  input  logic set_req,
  input  logic clr_req,
  output logic en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          en <= 1'b0;
    else if (!power_good) en <= 1'b0;
    else if (clr_req)    en <= 1'b0;
    else if (set_req)    en <= 1'b1;
  end

  // R2
  latch_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> $past(set_req) && $past(power_good));
  // R9
  latch_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> $past(clr_req) || !$past(power_good));
endmodule

// File: rtl/wp_cycle_timer.sv
module wp_cycle_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          start,
  input  logic [CW-1:0] dur,
  output logic          busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= dur - 1'b1;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cnt) == '0) || $past(abort));
  // R8
  no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/wp_array_sweeper.sv
module wp_array_sweeper
  import wp_seq_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          start,
  input  logic          full,
  input  logic          do_prog,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_wdata
);
  localparam logic [DW-1:0] ERASED = '1;

  wp_phase_e     ph;
  logic [AW-1:0] cur, base, stop;
  logic [DW-1:0] data_q;
  logic          prog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cur    <= '0;
      base   <= '0;
      stop   <= '0;
      data_q <= '0;
      prog_q <= 1'b0;
    end else if (abort) begin
      ph <= PH_IDLE;
    end else if (start) begin
      ph     <= PH_CLR;
      cur    <= full ? '0 : addr_in;
      base   <= full ? '0 : addr_in;
      stop   <= full ? '1 : addr_in;
      data_q <= data_in;
      prog_q <= do_prog;
    end else begin
      unique case (ph)
        PH_CLR: begin
          if (cur == stop) begin
            if (prog_q) begin
              ph  <= PH_PROG;
              cur <= base;
            end else begin
              ph <= PH_IDLE;
            end
          end else begin
            cur <= cur + 1'b1;
          end
        end
        PH_PROG: begin
          if (cur == stop) ph <= PH_IDLE;
          else             cur <= cur + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign arr_we    = (ph != PH_IDLE);
  assign arr_addr  = cur;
  assign arr_wdata = (ph == PH_PROG) ? data_q : ERASED;

  // R7
  prog_after_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_PROG && $past(ph) != PH_PROG) |-> ($past(ph) == PH_CLR));
endmodule

// File: rtl/wp_prog_sequencer.sv
module wp_prog_sequencer
  import wp_seq_pkg::*;
#(
  parameter int AW         = 4,
  parameter int DW         = 8,
  parameter int T_WORD_CYC = 1000,
  parameter int T_ERAL_CYC = 2000,
  parameter int T_WRAL_CYC = 3000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          power_good,
  input  logic          prog_en,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  output logic          busy,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_wdata
);
  localparam int T_MAX_A = (T_WORD_CYC > T_ERAL_CYC) ? T_WORD_CYC : T_ERAL_CYC;
  localparam int T_MAX   = (T_MAX_A > T_WRAL_CYC) ? T_MAX_A : T_WRAL_CYC;
  localparam int CW      = $clog2(T_MAX + 1);

  logic          wr_en;
  logic          take;
  logic          is_prog;
  logic          start;
  logic          abort;
  logic [CW-1:0] dur;

  assign cmd_ready = 1'b1;
  assign abort     = !power_good;
  assign take      = cmd_valid && power_good && !busy;
  assign is_prog   = (cmd_op == OP_ERASE) || (cmd_op == OP_WRITE) ||
                     (cmd_op == OP_ERAL)  || (cmd_op == OP_WRAL);
  assign start     = take && is_prog && wr_en && prog_en;

  always_comb begin
    unique case (cmd_op)
      OP_ERAL: dur = CW'(T_ERAL_CYC);
      OP_WRAL: dur = CW'(T_WRAL_CYC);
      default: dur = CW'(T_WORD_CYC);
    endcase
  end

  wp_enable_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .power_good (power_good),
    .set_req    (take && cmd_op == OP_EWEN),
    .clr_req    (take && cmd_op == OP_EWDS),
    .en         (wr_en)
  );

  wp_cycle_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .abort (abort),
    .start (start),
    .dur   (dur),
    .busy  (busy)
  );

  wp_array_sweeper #(.AW(AW), .DW(DW)) u_sweep (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (abort),
    .start     (start),
    .full      ((cmd_op == OP_ERAL) || (cmd_op == OP_WRAL)),
    .do_prog   ((cmd_op == OP_WRITE) || (cmd_op == OP_WRAL)),
    .addr_in   (cmd_addr),
    .data_in   (cmd_data),
    .arr_we    (arr_we),
    .arr_addr  (arr_addr),
    .arr_wdata (arr_wdata)
  );

  // R3
  start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(prog_en) && $past(wr_en) && $past(power_good));
  // R4
  we_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);
  // R9
  power_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !power_good |=> !busy && !arr_we);
  // R12
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready);
endmodule

// File: tb/tb_wp_prog_sequencer.sv
module tb_wp_prog_sequencer;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int TW = 20;
  localparam int TE = 40;
  localparam int TA = 48;
  localparam logic [DW-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic power_good = 1'b1;
  logic prog_en = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_op = 3'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic busy, arr_we;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] expm [DEPTH];
  int n_we, n_ones, order_err, exp_erase, bcyc;

  always #2.5 clk = ~clk;

  wp_prog_sequencer #(.AW(AW), .DW(DW), .T_WORD_CYC(TW), .T_ERAL_CYC(TE),
                      .T_WRAL_CYC(TA)) dut (
    .clk(clk), .rst_n(rst_n), .power_good(power_good), .prog_en(prog_en),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata));

  always @(posedge clk) begin
    if (arr_we) begin
      mem[arr_addr] <= arr_wdata;
      n_we = n_we + 1;
      if (arr_wdata == ONES) n_ones = n_ones + 1;
      else if (n_ones < exp_erase) order_err = order_err + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cmp_mem(input string tag);
    int bad = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] !== expm[i]) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  // drive one beat, then count busy cycles until it drops
  task automatic run_cmd(input logic [2:0] op, input int a, input int d, input int ne);
    @(negedge clk);
    n_we = 0; n_ones = 0; order_err = 0; exp_erase = ne;
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = AW'(a); cmd_data = DW'(d);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
    bcyc = 0;
    while (busy && bcyc < 1000) begin
      bcyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mem[i] = '0; expm[i] = '0; end
    n_we = 0; n_ones = 0; order_err = 0; exp_erase = 0; bcyc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(arr_we == 1'b0, "R1 arr_we after reset", arr_we, 0);
    chk(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);
    run_cmd(3'd4, 3, 8'h42, 1);
    chk(bcyc == 0 && n_we == 0, "R1 write dropped with latch clear", n_we, 0);

    run_cmd(3'd1, 0, 0, 0);
    prog_en = 1'b0;
    run_cmd(3'd4, 3, 8'h42, 1);
    chk(bcyc == 0 && n_we == 0, "R3 write dropped with prog_en low", n_we, 0);
    run_cmd(3'd5, 0, 0, DEPTH);
    chk(bcyc == 0 && n_we == 0, "R3 full erase dropped with prog_en low", n_we, 0);
    prog_en = 1'b1;

    for (int a = 0; a < DEPTH; a++) begin
      run_cmd(3'd4, a, a * 7 + 17, 1);
      expm[a] = DW'(a * 7 + 17);
      chk(bcyc == TW, "R5 R10 word write busy length", bcyc, TW);
      chk(n_we == 2 && order_err == 0, "R5 erase then program", n_we, 2);
      cmp_mem("R5 array after word write");
    end

    for (int k = 0; k < 3; k++) begin
      int a = (k == 0) ? 0 : ((k == 1) ? 5 : DEPTH - 1);
      run_cmd(3'd3, a, 0, 1);
      expm[a] = ONES;
      chk(bcyc == TW && n_we == 1, "R4 word erase busy and count", bcyc, TW);
      cmp_mem("R4 array after word erase");
    end

    // commands while busy are dropped
    @(negedge clk);
    n_we = 0; n_ones = 0; order_err = 0; exp_erase = 1;
    cmd_valid = 1'b1; cmd_op = 3'd4; cmd_addr = 4'd2; cmd_data = 8'h5A;
    @(negedge clk);
    cmd_op = 3'd2;
    chk(cmd_ready == 1'b1, "R12 ready while busy", cmd_ready, 1);
    @(negedge clk);
    cmd_op = 3'd4; cmd_addr = 4'd9; cmd_data = 8'h11;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
    while (busy) @(negedge clk);
    expm[2] = 8'h5A;
    chk(n_we == 2, "R8 writes while busy dropped", n_we, 2);
    cmp_mem("R8 array after busy drops");
    run_cmd(3'd4, 6, 8'h77, 1);
    expm[6] = 8'h77;
    chk(bcyc == TW, "R8 disable while busy dropped", bcyc, TW);

    run_cmd(3'd0, 1, 8'h22, 0);
    chk(bcyc == 0 && n_we == 0, "R11 opcode 0 no effect", n_we, 0);
    run_cmd(3'd7, 1, 8'h22, 0);
    chk(bcyc == 0 && n_we == 0, "R11 opcode 7 no effect", n_we, 0);
    run_cmd(3'd3, 1, 0, 1);
    expm[1] = ONES;
    chk(bcyc == TW, "R11 latch kept after unknown opcodes", bcyc, TW);
    cmp_mem("R11 array");

    run_cmd(3'd5, 0, 0, DEPTH);
    for (int i = 0; i < DEPTH; i++) expm[i] = ONES;
    chk(bcyc == TE && n_we == DEPTH, "R6 full erase busy", bcyc, TE);
    cmp_mem("R6 array all ones");

    run_cmd(3'd6, 0, 8'h3C, DEPTH);
    for (int i = 0; i < DEPTH; i++) expm[i] = 8'h3C;
    chk(bcyc == TA, "R7 full write busy", bcyc, TA);
    chk(n_we == 2 * DEPTH && order_err == 0, "R7 erase sweep before program sweep", n_we, 2 * DEPTH);
    cmp_mem("R7 array all data");

    run_cmd(3'd2, 0, 0, 0);
    run_cmd(3'd4, 4, 8'h99, 1);
    chk(bcyc == 0 && n_we == 0, "R2 write dropped after disable", n_we, 0);

    // power loss mid sweep
    run_cmd(3'd1, 0, 0, 0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd6; cmd_data = 8'h66;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
    repeat (4) @(negedge clk);
    power_good = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && arr_we == 1'b0, "R9 abort on power loss", busy, 0);
    cmd_valid = 1'b1; cmd_op = 3'd1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
    @(negedge clk);
    power_good = 1'b1;
    for (int i = 0; i < DEPTH; i++) expm[i] = mem[i];
    run_cmd(3'd4, 4, 8'h99, 1);
    chk(bcyc == 0 && n_we == 0, "R9 latch cleared by power loss", n_we, 0);
    cmp_mem("R9 array untouched");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule